// File: doc/BRIEF.md
# PHY Basic Control Register

This block holds the 16-bit basic control word of an Ethernet PHY. The word sits at one management address, set by a parameter and defaulting to 0. A serial management front end, not part of this block, reaches it through a plain address, write-strobe and write-data port, and reads it back on a registered read-data output. The block drives the PHY's control lines from the stored word: loopback, power down, isolate, auto-negotiation enable, a soft reset request and a single-cycle auto-negotiation restart pulse.

The speed and duplex that actually take effect are chosen by one rule. While auto-negotiation is enabled, they come from the auto-negotiation result inputs, and the manual bits are ignored. While it is disabled, they come from the manual speed and duplex bits.

Two bits clear themselves on a handshake from another block. The soft reset bit clears when the reset sequencer reports that it is done. The restart bit clears when the auto-negotiation engine acknowledges the start. Both the hardware reset and a soft reset reload the configuration from the strap inputs.

Top module: `phy_ctrl_reg`

## Requirements
- R1: In the first cycle after the hardware reset, the word reads as follows. Bit 13 equals `strap_speed`, bit 12 equals `strap_aneg`, bit 8 equals `strap_duplex`, and every other bit is 0 (with straps 1/1/0 the word is 0x3000).
- R2: A write with bit 15 = 1 starts a soft reset. From the next read onward, bit 15 reads 1, `soft_rst` is high, and all other bits hold their strap or default values. While the soft reset is in progress, writes are ignored, whatever they carry.
- R3: A one-cycle `rst_done` while the soft reset is in progress clears bit 15 and `soft_rst`. The other bits keep the strap values that were loaded.
- R4: With bit 15 = 0, a write stores bit 14 (loopback), bit 13 (speed, 1 = 100 Mb/s), bit 12 (auto-negotiation enable), bit 11 (power down), bit 10 (isolate) and bit 8 (duplex, 1 = full). The matching outputs follow the stored bits. Bits 7..0 always read 0.
- R5: While bit 12 is 0, `eff_speed` and `eff_duplex` equal bits 13 and 8. They are updated one cycle after the stored value changes.
- R6: While bit 12 is 1, `eff_speed` and `eff_duplex` equal `an_speed` and `an_duplex` as sampled one cycle earlier.
- R7: A write with bits 12 and 9 both 1, made while no restart is pending, has two effects. It raises `an_restart` for exactly one cycle, starting at the write edge. It also makes bit 9 read 1 until a one-cycle `an_started` clears it.
- R8: A write with bit 9 = 1 and bit 12 = 0 gives no `an_restart` pulse, and bit 9 reads 0.
- R9: While a restart is pending, neither a write of 0 nor a write of 1 to bit 9 clears the pending bit, and neither produces a pulse.
- R10: With `addr` different from the block's address, writes have no effect and `rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| addr | input | ADDR_W | Management register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data; shows the word as it stood before the previous edge |
| strap_speed | input | 1 | Strap default for the speed bit |
| strap_aneg | input | 1 | Strap default for the auto-negotiation enable bit |
| strap_duplex | input | 1 | Strap default for the duplex bit |
| rst_done | input | 1 | Reset sequencer completion pulse |
| an_started | input | 1 | Auto-negotiation engine start acknowledge |
| an_speed | input | 1 | Speed resolved by auto-negotiation |
| an_duplex | input | 1 | Duplex resolved by auto-negotiation |
| soft_rst | output | 1 | Soft reset request, high while bit 15 is set |
| loopback | output | 1 | Loopback enable |
| pwr_down | output | 1 | Power down |
| isolate | output | 1 | Isolate from the MII |
| an_enable | output | 1 | Auto-negotiation enable |
| an_restart | output | 1 | Single-cycle restart pulse |
| eff_speed | output | 1 | Speed that takes effect |
| eff_duplex | output | 1 | Duplex that takes effect |

## Verification
The assertions assume the following about the inputs:
- `rst_done` comes only while a soft reset is in progress, or is harmless outside one.
- `an_started` is a short acknowledge that follows a restart.
- The straps do not change in ways that matter while a soft reset holds its defaults.

The stimulus keeps within these limits. It raises each handshake for exactly one cycle, and only after the matching request is visible. It changes the straps only between resets. The main sweep walks all 64 combinations of the six writable control bits. In each step the auto-negotiation results are set opposite to the manual bits, so a wrong speed or duplex source shows at the outputs.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int REG_W     = 16;
  localparam int B_SRST    = 15;
  localparam int B_LOOP    = 14;
  localparam int B_SPEED   = 13;
  localparam int B_ANEG    = 12;
  localparam int B_PDOWN   = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DUPLEX  = 8;
  localparam logic [REG_W-1:0] CFG_MASK =
    (REG_W'(1) << B_LOOP) | (REG_W'(1) << B_SPEED) | (REG_W'(1) << B_ANEG) |
    (REG_W'(1) << B_PDOWN) | (REG_W'(1) << B_ISO) | (REG_W'(1) << B_DUPLEX);
endpackage

// File: rtl/phy_sc_bit.sv
module phy_sc_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic flush,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || flush) q <= 1'b0;
    else if (set)     q <= 1'b1;
    else if (clr)     q <= 1'b0;
  end

  // R3
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (q && !clr && !flush) |=> q);
endmodule

// File: rtl/phy_mode_sel.sv
module phy_mode_sel (
  input  logic clk,
  input  logic an_en,
  input  logic man_speed,
  input  logic man_duplex,
  input  logic an_speed,
  input  logic an_duplex,
  output logic eff_speed,
  output logic eff_duplex
);
  always_ff @(posedge clk) begin
    eff_speed  <= an_en ? an_speed  : man_speed;
    eff_duplex <= an_en ? an_duplex : man_duplex;
  end
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              strap_speed,
  input  logic              strap_aneg,
  input  logic              strap_duplex,
  input  logic              rst_done,
  input  logic              an_started,
  input  logic              an_speed,
  input  logic              an_duplex,
  output logic              soft_rst,
  output logic              loopback,
  output logic              pwr_down,
  output logic              isolate,
  output logic              an_enable,
  output logic              an_restart,
  output logic              eff_speed,
  output logic              eff_duplex
);
  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] dflt;
  logic             srst_q;
  logic             pend_q;
  logic             pulse_q;
  logic             addr_hit;
  logic             wr_hit;
  logic             srst_start;
  logic             cfg_wr;
  logic             restart_acc;

  assign addr_hit    = (addr == REG_ADDR);
  assign wr_hit      = wr_en && addr_hit;
  assign srst_start  = wr_hit && wdata[B_SRST] && !srst_q;
  assign cfg_wr      = wr_hit && !srst_q && !wdata[B_SRST];
  assign restart_acc = cfg_wr && wdata[B_ANEG] && wdata[B_RESTART] && !pend_q;

  always_comb begin
    dflt           = '0;
    dflt[B_SPEED]  = strap_speed;
    dflt[B_ANEG]   = strap_aneg;
    dflt[B_DUPLEX] = strap_duplex;
  end

  always_ff @(posedge clk) begin
    if (rst || srst_q || srst_start) cfg_q <= dflt;
    else if (cfg_wr)                 cfg_q <= wdata & CFG_MASK;
  end

  phy_sc_bit u_srst (
    .clk(clk), .rst(rst), .set(srst_start), .clr(rst_done),
    .flush(1'b0), .q(srst_q)
  );

  phy_sc_bit u_restart (
    .clk(clk), .rst(rst), .set(restart_acc), .clr(an_started),
    .flush(srst_q || srst_start), .q(pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= restart_acc;
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata <= '0;
    else if (addr_hit) rdata <= cfg_q | (REG_W'(srst_q) << B_SRST)
                                      | (REG_W'(pend_q) << B_RESTART);
    else               rdata <= '0;
  end

  phy_mode_sel u_mode (
    .clk(clk), .an_en(cfg_q[B_ANEG]),
    .man_speed(cfg_q[B_SPEED]), .man_duplex(cfg_q[B_DUPLEX]),
    .an_speed(an_speed), .an_duplex(an_duplex),
    .eff_speed(eff_speed), .eff_duplex(eff_duplex)
  );

  assign soft_rst   = srst_q;
  assign loopback   = cfg_q[B_LOOP];
  assign pwr_down   = cfg_q[B_PDOWN];
  assign isolate    = cfg_q[B_ISO];
  assign an_enable  = cfg_q[B_ANEG];
  assign an_restart = pulse_q;

  // R7
  pulse_with_pending_chk: assert property (@(posedge clk) disable iff (rst)
    an_restart |-> pend_q);

  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    an_restart |=> !an_restart);

  // R2
  srst_defaults_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (!loopback && !pwr_down && !isolate && !pend_q));

  // R6
  an_source_chk: assert property (@(posedge clk) disable iff (rst)
    $past(an_enable) |-> (eff_speed == $past(an_speed) && eff_duplex == $past(an_duplex)));

  // R5
  man_source_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(an_enable) |-> (eff_speed == $past(cfg_q[B_SPEED]) &&
                           eff_duplex == $past(cfg_q[B_DUPLEX])));
endmodule

// File: tb/tb_phy_ctrl_reg.sv
`timescale 1ns/1ps
module tb_phy_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        strap_speed = 1'b1, strap_aneg = 1'b1, strap_duplex = 1'b0;
  logic        rst_done = 1'b0, an_started = 1'b0;
  logic        an_speed = 1'b0, an_duplex = 1'b0;
  logic        soft_rst, loopback, pwr_down, isolate, an_enable, an_restart;
  logic        eff_speed, eff_duplex;
  int          checks = 0;
  int          failures = 0;
  logic        pulse_seen;
  logic        pulse_after;

  phy_ctrl_reg dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .strap_speed(strap_speed), .strap_aneg(strap_aneg), .strap_duplex(strap_duplex),
    .rst_done(rst_done), .an_started(an_started), .an_speed(an_speed),
    .an_duplex(an_duplex), .soft_rst(soft_rst), .loopback(loopback),
    .pwr_down(pwr_down), .isolate(isolate), .an_enable(an_enable),
    .an_restart(an_restart), .eff_speed(eff_speed), .eff_duplex(eff_duplex)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; pulse_seen = an_restart;
    @(negedge clk); pulse_after = an_restart;
  endtask

  task automatic pulse_done();
    @(negedge clk); rst_done = 1'b1;
    @(negedge clk); rst_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); an_started = 1'b1;
    @(negedge clk); an_started = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset word", rdata, 16'h3000);
    chk("R1 reset outputs", {12'h0, soft_rst, loopback, pwr_down, isolate}, 16'h0);
    chk("R1 reset aneg", {15'h0, an_enable}, 16'h1);

    for (int v = 0; v < 64; v++) begin
      logic [5:0] b;
      logic [15:0] exp_w;
      b = v[5:0];
      an_speed  = ~b[4];
      an_duplex = ~b[0];
      exp_w = {1'b0, b[5], b[4], b[3], b[2], b[1], 1'b0, b[0], 8'h00};
      wr({1'b0, b[5], b[4], b[3], b[2], b[1], 1'b0, b[0], 8'hFF});
      chk("R4 readback", rdata, exp_w);
      chk("R4 outputs", {12'h0, loopback, an_enable, pwr_down, isolate},
          {12'h0, b[5], b[3], b[2], b[1]});
      if (b[3])
        chk("R6 effective from aneg", {14'h0, eff_speed, eff_duplex}, {14'h0, ~b[4], ~b[0]});
      else
        chk("R5 effective from manual", {14'h0, eff_speed, eff_duplex}, {14'h0, b[4], b[0]});
      chk("R8 no stray pulse", {15'h0, pulse_seen}, 16'h0);
    end

    // R6: one-cycle tracking of result inputs
    wr(16'h1000);
    an_speed = 1'b1; an_duplex = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R6 tracking", {14'h0, eff_speed, eff_duplex}, 16'h0002);

    // R7 and R9
    wr(16'h1200);
    chk("R7 pulse at write", {15'h0, pulse_seen}, 16'h1);
    chk("R7 pulse single", {15'h0, pulse_after}, 16'h0);
    chk("R7 bit9 pending", rdata, 16'h1200);
    wr(16'h1200);
    chk("R9 no second pulse", {15'h0, pulse_seen}, 16'h0);
    wr(16'h1000);
    chk("R9 zero write keeps pending", rdata, 16'h1200);
    pulse_ack();
    chk("R7 cleared by ack", rdata, 16'h1000);
    wr(16'h1200);
    chk("R7 pulse again after ack", {15'h0, pulse_seen}, 16'h1);
    pulse_ack();

    // R8
    wr(16'h0200);
    chk("R8 ignored pulse", {15'h0, pulse_seen}, 16'h0);
    chk("R8 ignored bit", rdata, 16'h0000);

    // R10
    wr(16'h0000);
    addr = 5'd1;
    wr(16'h4C00);
    chk("R10 other address reads 0", rdata, 16'h0000);
    addr = 5'd0;
    @(negedge clk);
    chk("R10 other address write ignored", rdata, 16'h0000);
    chk("R10 loopback unchanged", {15'h0, loopback}, 16'h0);

    // R2 and R3
    wr(16'h4C00);
    strap_speed = 1'b0; strap_aneg = 1'b0; strap_duplex = 1'b1;
    wr(16'hFFFF);
    chk("R2 soft reset word", rdata, 16'h8100);
    chk("R2 soft reset outputs", {12'h0, soft_rst, loopback, pwr_down, isolate}, 16'h0008);
    wr(16'h4C00);
    chk("R2 write ignored in reset", rdata, 16'h8100);
    chk("R2 loopback held", {15'h0, loopback}, 16'h0);
    pulse_done();
    chk("R3 cleared word", rdata, 16'h0100);
    chk("R3 soft_rst low", {15'h0, soft_rst}, 16'h0);
    wr(16'h4000);
    chk("R3 writes accepted after", rdata, 16'h4000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule